// File: doc/BRIEF.md
# Dual-Lane Q15 Fractional Multiplier with Rounding

This block multiplies two signed Q15 fractions per lane, with two 16-bit lanes packed in each 32-bit operand. Each lane forms the signed product, doubles it to reach Q31 alignment, and can add half an output LSB before it keeps the upper half. The single operand pair whose doubled product cannot be represented (minus one times minus one) is caught before the multiply and clamps to the largest positive fraction. A sticky flag records that a clamp happened and stays set until it is cleared.

Rounding is requested in either of two ways. The `in_round` pin requests it directly. A small decoder also requests it when `in_insn` carries the rounding multiply encoding. Operands enter on a valid/ready stream, and the result leaves on a second valid/ready stream through one output register.

The back-pressure rules are as follows. The input is accepted on a rising edge when `in_valid` and `in_ready` are both high. `in_ready` is high while the output register is empty or is being drained in that same cycle. While `out_valid` is high and `out_ready` is low, `out_word` holds its value and no new operand is taken.

Top module: `q15_mulq`

## Requirements
- R1: Without rounding, each lane output is bits [31:16] of the doubled signed 16x16 product, so the value is truncated.
- R2: With rounding, 0x8000 is added to the doubled product before bits [31:16] are kept, so a low half of exactly 0x8000 carries into the result.
- R3: `in_insn` requests rounding when bits [31:26] are 011111, bits [10:6] are 11111 and bits [5:0] are 010000, whatever the other bits hold. Any other word leaves rounding to `in_round`.
- R4: A lane whose two inputs are both 0x8000 outputs 0x7FFF, with or without rounding.
- R5: Lane 0 uses bits [15:0] of the operands and of the result, and lane 1 uses bits [31:16]. A clamp in one lane does not change the other lane.
- R6: An operand accepted on a rising edge appears on `out_word` with `out_valid` high right after that edge.
- R7: While `out_valid` is high and `out_ready` is low, `in_ready` is low and `out_word` and `out_valid` hold.
- R8: `sat_flag` goes high after an accepted operand that clamps in any lane. It then stays high until it is cleared.
- R9: `sat_clr` clears `sat_flag` on the next edge. If a clamping operand is accepted on the same edge, the flag stays set.
- R10: After reset `out_valid` and `sat_flag` are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand pair is valid |
| in_ready | output | 1 | Block can take an operand pair |
| in_a | input | 32 | First packed operand |
| in_b | input | 32 | Second packed operand |
| in_round | input | 1 | Direct rounding request |
| in_insn | input | 32 | Instruction word; the rounding encoding requests rounding |
| out_valid | output | 1 | Result is valid |
| out_ready | input | 1 | Consumer can take the result |
| out_word | output | 32 | Packed result |
| sat_clr | input | 1 | Clear for the sticky clamp flag |
| sat_flag | output | 1 | Sticky clamp flag |

## Verification
The checker watches, on every cycle, that the output holds under back-pressure, that an accepted operand always produces a valid output, that a minus-one pair gives 0x7FFF in its lane, and that the sticky flag sets on a clamp and never drops without a clear. The arithmetic itself (truncation, the rounding carry at a low half of 0x8000, lane placement and the decode of the instruction pattern) can only be shown by the bench, which compares every result against its own model over directed corner operands and random ones.

// File: rtl/q15_pkg.sv
package q15_pkg;
  // Rounding-multiply instruction pattern: the mask selects the fixed fields
  localparam logic [31:0] RND_INSN_MASK = 32'hFC00_07FF;
  localparam logic [31:0] RND_INSN_PAT  = {6'b011111, 15'd0, 5'b11111, 6'b010000};
endpackage

// File: rtl/q15_rnd_decode.sv
module q15_rnd_decode
  import q15_pkg::*;
(
  input  logic [31:0] insn,
  output logic        is_rnd
);
  always_comb is_rnd = ((insn & RND_INSN_MASK) == RND_INSN_PAT);
endmodule

// File: rtl/q15_lane.sv
module q15_lane #(
  parameter int LW = 16
) (
  input  logic [LW-1:0] a,
  input  logic [LW-1:0] b,
  input  logic          rnd,
  output logic [LW-1:0] res,
  output logic          sat
);
  localparam int PW = 2 * LW;
  localparam logic [LW-1:0] MINV = {1'b1, {(LW-1){1'b0}}};
  localparam logic [LW-1:0] MAXV = {1'b0, {(LW-1){1'b1}}};
  localparam logic [PW-1:0] HALF = {{LW{1'b0}}, 1'b1, {(LW-1){1'b0}}};

  logic signed [LW-1:0] sa, sb;
  logic signed [PW-1:0] prod;
  logic        [PW-1:0] dbl, sum;

  always_comb begin
    sa   = a;
    sb   = b;
    sat  = (a == MINV) && (b == MINV);
    prod = sa * sb;
    dbl  = prod <<< 1;
    sum  = dbl + (rnd ? HALF : '0);
    res  = sat ? MAXV : sum[PW-1:LW];
  end
endmodule

// File: rtl/q15_mulq.sv
module q15_mulq #(
  parameter int LANES = 2,
  parameter int LW    = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [LANES*LW-1:0] in_a,
  input  logic [LANES*LW-1:0] in_b,
  input  logic                in_round,
  input  logic [31:0]         in_insn,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [LANES*LW-1:0] out_word,
  input  logic                sat_clr,
  output logic                sat_flag
);
  localparam int DW = LANES * LW;

  logic          dec_rnd, rnd, accept;
  logic [DW-1:0] lane_res;
  logic [LANES-1:0] lane_sat;

  q15_rnd_decode u_dec (.insn(in_insn), .is_rnd(dec_rnd));

  assign rnd = in_round | dec_rnd;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    q15_lane #(.LW(LW)) u_lane (
      .a  (in_a[g*LW +: LW]),
      .b  (in_b[g*LW +: LW]),
      .rnd(rnd),
      .res(lane_res[g*LW +: LW]),
      .sat(lane_sat[g])
    );
  end

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_word  <= '0;
      sat_flag  <= 1'b0;
    end else begin
      if (accept) begin
        out_valid <= 1'b1;
        out_word  <= lane_res;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
      if (accept && |lane_sat) sat_flag <= 1'b1;
      else if (sat_clr)        sat_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/q15_mulq_chk.sv
module q15_mulq_chk #(
  parameter int LANES = 2,
  parameter int LW    = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic                in_ready,
  input logic [LANES*LW-1:0] in_a,
  input logic [LANES*LW-1:0] in_b,
  input logic                out_valid,
  input logic                out_ready,
  input logic [LANES*LW-1:0] out_word,
  input logic                sat_clr,
  input logic                sat_flag
);
  localparam logic [LW-1:0] MINV = {1'b1, {(LW-1){1'b0}}};
  localparam logic [LW-1:0] MAXV = {1'b0, {(LW-1){1'b1}}};

  // R7
  hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_word));

  // R7
  stall_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  // R6
  accept_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  // R8
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sat_flag && !sat_clr |=> sat_flag);

  for (genvar g = 0; g < LANES; g++) begin : g_chk
    // R4
    lane_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready && in_a[g*LW +: LW] == MINV && in_b[g*LW +: LW] == MINV
      |=> out_word[g*LW +: LW] == MAXV && sat_flag);
  end
endmodule

bind q15_mulq q15_mulq_chk #(.LANES(LANES), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_ready(out_ready),
  .out_word(out_word), .sat_clr(sat_clr), .sat_flag(sat_flag)
);

// File: tb/test_q15_mulq.sv
module test_q15_mulq;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        in_valid = 0, in_round = 0, out_ready = 1, sat_clr = 0;
  logic [31:0] in_a = 0, in_b = 0, in_insn = 0;
  logic        in_ready, out_valid, sat_flag;
  logic [31:0] out_word;
  int nchk = 0, nbad = 0;

  always #2.5 clk = ~clk;

  q15_mulq i_q15_mulq (.*);

  function automatic logic [15:0] ref_lane(logic [15:0] a, logic [15:0] b, bit r);
    longint p;
    if (a == 16'h8000 && b == 16'h8000) return 16'h7FFF;
    p = longint'($signed(a)) * longint'($signed(b)) * 2;
    if (r) p = p + 32768;
    return 16'(p >>> 16);
  endfunction

  function automatic logic [31:0] ref_word(logic [31:0] a, logic [31:0] b, bit r);
    return {ref_lane(a[31:16], b[31:16], r), ref_lane(a[15:0], b[15:0], r)};
  endfunction

  function automatic logic [31:0] rnd_insn();
    return {6'b011111, 15'($urandom), 5'b11111, 6'b010000};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive at negedge, accepted at next posedge, sampled at following negedge
  task automatic send(logic [31:0] a, logic [31:0] b, bit r, logic [31:0] insn,
                      bit rexp, string req);
    @(negedge clk);
    in_a = a; in_b = b; in_round = r; in_insn = insn; in_valid = 1; out_ready = 1;
    @(negedge clk);
    in_valid = 0;
    chk({req, " valid (R6)"}, 32'(out_valid), 32'd1);
    chk(req, out_word, ref_word(a, b, rexp));
  endtask

  initial begin
    #50000;
    nbad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R10
    chk("R10 out_valid", 32'(out_valid), 0);
    chk("R10 sat_flag", 32'(sat_flag), 0);
    chk("R10 in_ready", 32'(in_ready), 1);

    // R1 truncation, R2 rounding carry boundary
    send(32'h0001_0001, 32'h4000_4000, 0, 0, 0, "R1 trunc 0x8000 low half");
    chk("R1 exact", out_word, 32'h0000_0000);
    send(32'h0001_0001, 32'h4000_4000, 1, 0, 1, "R2 carry");
    chk("R2 exact", out_word, 32'h0001_0001);
    send(32'hFFFF_7FFF, 32'h4000_7FFF, 1, 0, 1, "R2 neg/max");
    chk("R2 exact neg/max", out_word, 32'h0000_7FFE);
    send(32'hFFFF_0003, 32'h4000_4000, 0, 0, 0, "R1 neg trunc");
    chk("R1 exact neg", out_word, 32'hFFFF_0001);
    chk("R10 sat_flag still clear", 32'(sat_flag), 0);

    // R3 decoder
    send(32'h0001_0001, 32'h4000_4000, 0, rnd_insn(), 1, "R3 pattern rounds");
    send(32'h0001_0001, 32'h4000_4000, 0, rnd_insn() ^ 32'h1, 0, "R3 func mismatch");
    send(32'h0001_0001, 32'h4000_4000, 0, rnd_insn() ^ 32'h40, 0, "R3 const mismatch");

    // R4 / R5 clamp, lane independence, R8 sticky
    send(32'h8000_1234, 32'h8000_4321, 0, 0, 0, "R5 clamp hi lane");
    chk("R4 hi lane", out_word, {16'h7FFF, ref_lane(16'h1234, 16'h4321, 0)});
    chk("R8 set", 32'(sat_flag), 1);
    send(32'h0101_0202, 32'h0303_0404, 0, 0, 0, "R8 normal op");
    chk("R8 held", 32'(sat_flag), 1);
    @(negedge clk); sat_clr = 1;
    @(negedge clk); sat_clr = 0;
    chk("R9 cleared", 32'(sat_flag), 0);
    send(32'h5555_8000, 32'h7FFF_8000, 1, 0, 1, "R4 clamp lo lane rnd");
    chk("R4 lo lane", out_word[15:0], 32'h7FFF);
    @(negedge clk); sat_clr = 1;
    @(negedge clk); sat_clr = 0;
    // R9 set wins over clear
    @(negedge clk);
    in_a = 32'h8000_8000; in_b = 32'h8000_8000; in_round = 0; in_insn = 0;
    in_valid = 1; sat_clr = 1;
    @(negedge clk);
    in_valid = 0; sat_clr = 0;
    chk("R9 set beats clear", 32'(sat_flag), 1);
    chk("R4 both lanes", out_word, 32'h7FFF_7FFF);

    // R7 back-pressure
    @(negedge clk);
    out_ready = 0; in_a = 32'h1000_2000; in_b = 32'h3000_4000; in_valid = 1;
    @(negedge clk);
    chk("R7 first result", out_word, ref_word(32'h1000_2000, 32'h3000_4000, 0));
    chk("R7 in_ready low", 32'(in_ready), 0);
    in_a = 32'h7777_6666;
    @(negedge clk);
    chk("R7 held word", out_word, ref_word(32'h1000_2000, 32'h3000_4000, 0));
    chk("R7 held valid", 32'(out_valid), 1);
    out_ready = 1;
    @(negedge clk);
    in_valid = 0;
    chk("R7 next after drain", out_word, ref_word(32'h7777_6666, 32'h3000_4000, 0));
    @(negedge clk);
    chk("R6 drained", 32'(out_valid), 0);

    // random mix
    for (int i = 0; i < 300; i++) begin
      logic [31:0] a, b;
      bit r, useins;
      a = $urandom; b = $urandom;
      if ($urandom_range(0, 7) == 0) begin a[15:0] = 16'h8000; b[15:0] = 16'h8000; end
      if ($urandom_range(0, 7) == 0) begin a[31:16] = 16'h8000; b[31:16] = 16'h8000; end
      r = 1'($urandom); useins = 1'($urandom);
      send(a, b, r, useins ? rnd_insn() : 32'($urandom) & 32'hFFFF_F000,
           r | useins, "R1/R2/R5 random");
    end

    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end
endmodule